// File: doc/BRIEF.md
# Frame-Aligned Programmable Derandomizer

This block takes a serial bit stream that a frame synchronizer has already aligned, and strips the pseudo-random scrambling applied at the transmitter. Each payload bit is XORed with a key bit from a linear feedback shift register. The register length, feedback taps and starting state are all set through configuration inputs. A pulse from the frame synchronizer reseeds the register on the first bit of every sync marker. Key bits are applied only once a programmable number of bits, counted from that marker bit, has gone by.

Configuration is sampled on the frame-start bit and held for the rest of that frame. Software can therefore rewrite the configuration inputs at any time without corrupting the frame in flight. A disable setting turns the block into a one-cycle pipeline stage that passes the data through unchanged. Until the first frame-start pulse after reset, the block also passes data through unchanged.

Top module: `lfsr_derand`

## Requirements
- R1: After reset `bit_valid_o` is low, and until the first `frame_start_i` every valid bit leaves unchanged.
- R2: Output is registered with a latency of one cycle: `bit_valid_o` follows `bit_valid_i` one cycle later, and `bit_o` carries the bit sampled in that same earlier cycle.
- R3: `frame_start_i` is asserted together with the first sync-marker bit. Enable, taps, seed, length and offset are sampled in that cycle and govern the whole frame. Later changes to the configuration inputs take effect only at the next frame start.
- R4: Bits with in-frame index below the offset pass unchanged, and the register does not advance on them. The frame-start bit has index 0. The offset is 8 bits wide and supports at least 0 to 160. From index = offset on, bits are XORed with consecutive key bits.
- R5: Tap encoding: bit k of `cfg_poly_i`, for k below the length L, is the coefficient of x^k. The x^L term is implied. Tap bits at position L or above are ignored. Keys obey a[n+L] = XOR over k<L of poly[k]·a[n+k].
- R6: The first L key bits of a frame are the seed bits `cfg_seed_i[L-1]` down to `cfg_seed_i[0]`. Each key bit is taken before the shift that produces the next one.
- R7: The register length is selected from 7 to 15 stages by `cfg_len_i`. Codes below 7 act as 7.
- R8: With `cfg_enable_i` low at frame start, every bit of that frame passes through unchanged.
- R9: Cycles without `bit_valid_i` neither advance the register nor count toward the offset.
- R10: Taps 16'h00A9 with length 8 and seed 16'h00FF reproduce the standard space-link randomizer sequence, which begins with the bytes FF 48 0E C0. These values are also the held-configuration reset values.
- R11: A frame-start pulse in the middle of a frame reseeds the register and restarts the offset count from that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_start_i | input | 1 | Marks the first sync-marker bit; sampled with bit_valid_i |
| bit_valid_i | input | 1 | Input bit qualifier |
| bit_i | input | 1 | Serial input bit |
| cfg_enable_i | input | 1 | 1 = derandomize, 0 = pass through |
| cfg_poly_i | input | 16 | Feedback taps, bit k = coefficient of x^k |
| cfg_seed_i | input | 16 | Register seed, low L bits used |
| cfg_len_i | input | 4 | Register length L (7..15) |
| cfg_offset_i | input | 8 | Bits to skip from the marker start |
| bit_valid_o | output | 1 | Output bit qualifier |
| bit_o | output | 1 | Serial output bit |

## Verification
The bench puts the key on the frame-start bit when the offset is zero, and at the 160-bit limit. A design that counts from the bit after the marker, or that shifts during skipped bits, misaligns every later key bit. It changes the configuration mid-frame, which exposes a design that applies new taps immediately instead of at the next frame. It inserts idle cycles between bits, which catches a register that advances on invalid cycles. It also uses length codes below 7, tap words with bits set above the length, and a frame restarted before the previous one ends. A wrong tap or length mapping shows up as a diverging key sequence, and a missing reseed leaves the old state running.

// File: rtl/derand_pkg.sv
package derand_pkg;
  localparam int unsigned LFSR_W  = 16;
  localparam int unsigned LEN_W   = 4;
  localparam int unsigned OFF_W   = 8;
  localparam int unsigned MIN_LEN = 7;

  localparam logic [LFSR_W-1:0] STD_POLY = 16'h00A9;
  localparam logic [LFSR_W-1:0] STD_SEED = 16'h00FF;
  localparam logic [LEN_W-1:0]  STD_LEN  = 4'd8;

  typedef struct packed {
    logic              en;
    logic [LFSR_W-1:0] poly;
    logic [LFSR_W-1:0] seed;
    logic [LEN_W-1:0]  len;
    logic [OFF_W-1:0]  off;
  } derand_cfg_t;
endpackage

// File: rtl/derand_cfg_hold.sv
module derand_cfg_hold
  import derand_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        fs_i,
  input  derand_cfg_t cfg_i,
  output derand_cfg_t cfg_o
);
  derand_cfg_t cfg_in_c, held_q;

  always_comb begin
    cfg_in_c = cfg_i;
    if (cfg_i.len < LEN_W'(MIN_LEN)) cfg_in_c.len = LEN_W'(MIN_LEN);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q.en   <= 1'b1;
      held_q.poly <= STD_POLY;
      held_q.seed <= STD_SEED;
      held_q.len  <= STD_LEN;
      held_q.off  <= '0;
    end else if (fs_i) begin
      held_q <= cfg_in_c;
    end
  end

  // frame-start bit already uses the fresh settings
  assign cfg_o = fs_i ? cfg_in_c : held_q;
endmodule

// File: rtl/derand_gate.sv
module derand_gate #(
  parameter int unsigned OFF_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fs_i,
  input  logic             valid_i,
  input  logic [OFF_W-1:0] off_i,
  output logic             active_o
);
  logic             armed_q, armed_c;
  logic [OFF_W-1:0] remain_q, remain_c;

  assign armed_c  = fs_i | armed_q;
  assign remain_c = fs_i ? off_i : remain_q;
  assign active_o = armed_c && (remain_c == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q  <= 1'b0;
      remain_q <= '0;
    end else begin
      armed_q <= armed_c;
      if (valid_i && armed_c && remain_c != '0) remain_q <= remain_c - 1'b1;
      else                                       remain_q <= remain_c;
    end
  end
endmodule

// File: rtl/derand_lfsr.sv
module derand_lfsr #(
  parameter int unsigned W     = 16,
  parameter int unsigned LEN_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             step_i,
  input  logic [W-1:0]     seed_i,
  input  logic [W-1:0]     poly_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             key_o
);
  logic [W-1:0]     state_q, cur_c;
  logic [LEN_W-1:0] top_idx;
  logic             fb_c;

  assign cur_c   = load_i ? seed_i : state_q;
  assign top_idx = len_i - 1'b1;
  assign key_o   = cur_c[top_idx];

  // stage j holds a[n+L-1-j]; tap k pairs with a[n+k]
  always_comb begin
    fb_c = 1'b0;
    for (int j = 0; j < int'(W); j++) begin
      if (j < int'(len_i))
        fb_c = fb_c ^ (poly_i[LEN_W'(int'(len_i) - 1 - j)] & cur_c[j]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_q <= '1;
    else if (step_i) state_q <= {cur_c[W-2:0], fb_c};
    else             state_q <= cur_c;
  end
endmodule

// File: rtl/lfsr_derand.sv
module lfsr_derand
  import derand_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_start_i,
  input  logic              bit_valid_i,
  input  logic              bit_i,
  input  logic              cfg_enable_i,
  input  logic [LFSR_W-1:0] cfg_poly_i,
  input  logic [LFSR_W-1:0] cfg_seed_i,
  input  logic [LEN_W-1:0]  cfg_len_i,
  input  logic [OFF_W-1:0]  cfg_offset_i,
  output logic              bit_valid_o,
  output logic              bit_o
);
  derand_cfg_t cfg_raw, cfg_eff;
  logic        active, key, step;
  logic        valid_q, bit_q;

  assign cfg_raw = '{en: cfg_enable_i, poly: cfg_poly_i, seed: cfg_seed_i,
                     len: cfg_len_i, off: cfg_offset_i};

  derand_cfg_hold i_cfg (
    .clk_i (clk_i), .rst_ni(rst_ni), .fs_i(frame_start_i),
    .cfg_i (cfg_raw), .cfg_o(cfg_eff)
  );

  derand_gate #(.OFF_W(OFF_W)) i_gate (
    .clk_i (clk_i), .rst_ni(rst_ni), .fs_i(frame_start_i),
    .valid_i(bit_valid_i), .off_i(cfg_eff.off), .active_o(active)
  );

  assign step = bit_valid_i & active;

  derand_lfsr #(.W(LFSR_W), .LEN_W(LEN_W)) i_lfsr (
    .clk_i (clk_i), .rst_ni(rst_ni), .load_i(frame_start_i), .step_i(step),
    .seed_i(cfg_eff.seed), .poly_i(cfg_eff.poly), .len_i(cfg_eff.len),
    .key_o (key)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      bit_q   <= 1'b0;
    end else begin
      valid_q <= bit_valid_i;
      bit_q   <= bit_i ^ (step & cfg_eff.en & key);
    end
  end

  assign bit_valid_o = valid_q;
  assign bit_o       = bit_q;
endmodule

// File: rtl/derand_chk.sv
module derand_chk
  import derand_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              frame_start_i,
  input logic              bit_valid_i,
  input logic              bit_i,
  input logic              cfg_enable_i,
  input logic [LFSR_W-1:0] cfg_seed_i,
  input logic [LEN_W-1:0]  cfg_len_i,
  input logic [OFF_W-1:0]  cfg_offset_i,
  input logic              bit_valid_o,
  input logic              bit_o
);
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            seen_q <= 1'b0;
    else if (frame_start_i) seen_q <= 1'b1;
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_valid_i |=> bit_valid_o);
  // R2
  idle_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_valid_i |=> !bit_valid_o);
  // R1
  pre_frame_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!seen_q && !frame_start_i && bit_valid_i) |=> (bit_o == $past(bit_i)));
  // R8
  bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_start_i && bit_valid_i && !cfg_enable_i) |=> (bit_o == $past(bit_i)));
  // R4
  offset_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_start_i && bit_valid_i && cfg_offset_i != '0) |=> (bit_o == $past(bit_i)));
  // R6
  first_key_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_start_i && bit_valid_i && cfg_enable_i && cfg_offset_i == '0 && cfg_len_i == 4'd8)
    |=> (bit_o == $past(bit_i ^ cfg_seed_i[7])));
endmodule

bind lfsr_derand derand_chk i_derand_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .frame_start_i(frame_start_i),
  .bit_valid_i  (bit_valid_i),
  .bit_i        (bit_i),
  .cfg_enable_i (cfg_enable_i),
  .cfg_seed_i   (cfg_seed_i),
  .cfg_len_i    (cfg_len_i),
  .cfg_offset_i (cfg_offset_i),
  .bit_valid_o  (bit_valid_o),
  .bit_o        (bit_o)
);

// File: tb/test_lfsr_derand.sv
module test_lfsr_derand;
  localparam int CLK_P = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        fs = 1'b0, vld = 1'b0, din = 1'b0;
  logic        en_r = 1'b1;
  logic [15:0] poly_r = 16'h00A9, seed_r = 16'h00FF;
  logic [3:0]  len_r = 4'd8;
  logic [7:0]  off_r = 8'd0;
  logic        vld_o, dout;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [31:0] cap;
  bit keys [0:1023];

  always #(CLK_P/2) clk = ~clk;

  lfsr_derand i_lfsr_derand (
    .clk_i(clk), .rst_ni(rst_n), .frame_start_i(fs), .bit_valid_i(vld), .bit_i(din),
    .cfg_enable_i(en_r), .cfg_poly_i(poly_r), .cfg_seed_i(seed_r), .cfg_len_i(len_r),
    .cfg_offset_i(off_r), .bit_valid_o(vld_o), .bit_o(dout)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cycle(input logic f, input logic v, input logic b);
    @(negedge clk);
    fs = f; vld = v; din = b;
    @(posedge clk);
    #1;
  endtask

  task automatic build_keys(input logic [15:0] p, input logic [15:0] s, input int l);
    for (int i = 0; i < l; i++) keys[i] = s[l-1-i];
    for (int n = 0; n + l < 1024; n++) begin
      bit fb = 1'b0;
      for (int k = 0; k < l; k++) fb ^= p[k] & keys[n+k];
      keys[n+l] = fb;
    end
  endtask

  // one frame; chg scrambles the config inputs after the first bit
  task automatic run_frame(input string tag, input logic e, input logic [15:0] p,
                           input logic [15:0] s, input logic [3:0] l, input logic [7:0] o,
                           input int nbits, input int gap, input bit chg, input int salt);
    int le = (l < 4'd7) ? 7 : int'(l);
    build_keys(p, s, le);
    @(negedge clk);
    en_r = e; poly_r = p; seed_r = s; len_r = l; off_r = o;
    for (int i = 0; i < nbits; i++) begin
      logic d = logic'(((i * 7 + salt) % 3) == 0);
      logic x = (e && i >= int'(o)) ? (d ^ keys[i - int'(o)]) : d;
      cycle(i == 0, 1'b1, d);
      check(tag, dout, x);
      check("R2", vld_o, 1'b1);
      cap = {cap[30:0], dout};
      if (chg && i == 0) begin
        en_r = ~e; poly_r = p ^ 16'h0F0F; seed_r = ~s; len_r = 4'd13; off_r = o + 8'd3;
      end
      for (int g = 0; g < gap; g++) begin
        cycle(1'b0, 1'b0, 1'b1);
        check("R9", vld_o, 1'b0);
      end
    end
    cycle(1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_reset;
    check("R1", vld_o, 1'b0);
    for (int i = 0; i < 6; i++) begin
      logic d = logic'(i % 2);
      cycle(1'b0, 1'b1, d);
      check("R1", dout, d);
      check("R2", vld_o, 1'b1);
    end
    cycle(1'b0, 1'b0, 1'b0);
    check("R2", vld_o, 1'b0);
  endtask

  task automatic t_standard;
    cap = '0;
    run_frame("R10", 1'b1, 16'h00A9, 16'h00FF, 4'd8, 8'd0, 32, 0, 1'b0, 1);
    // all-zero data not used: undo data pattern by recomputing key bits
    build_keys(16'h00A9, 16'h00FF, 8);
    begin
      logic [31:0] kv;
      for (int i = 0; i < 32; i++) kv[31-i] = keys[i];
      check("R10", logic'(kv == 32'hFF480EC0), 1'b1);
    end
    @(negedge clk);
    en_r = 1'b1; poly_r = 16'h00A9; seed_r = 16'h00FF; len_r = 4'd8; off_r = 8'd0;
    cap = '0;
    for (int i = 0; i < 32; i++) begin
      cycle(i == 0, 1'b1, 1'b0);
      cap = {cap[30:0], dout};
    end
    checks++;
    if (cap !== 32'hFF480EC0) begin
      fails++;
      $display("FAIL R10: got %h expected %h", cap, 32'hFF480EC0);
    end
    cycle(1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_offset;
    run_frame("R4", 1'b1, 16'h00A9, 16'h00FF, 4'd8, 8'd5, 40, 0, 1'b0, 2);
    run_frame("R4", 1'b1, 16'h00A9, 16'h00FF, 4'd8, 8'd160, 200, 0, 1'b0, 3);
  endtask

  task automatic t_taps;
    run_frame("R5", 1'b1, 16'h0041, 16'h0055, 4'd7, 8'd0, 60, 0, 1'b0, 4);
    run_frame("R7", 1'b1, 16'h4003, 16'h7ABC, 4'd15, 8'd2, 80, 0, 1'b0, 5);
    run_frame("R5", 1'b1, 16'hFE21, 16'h01A5, 4'd9, 8'd1, 60, 0, 1'b0, 6);
    run_frame("R6", 1'b1, 16'h0087, 16'h0C3A, 4'd12, 8'd0, 30, 0, 1'b0, 7);
  endtask

  task automatic t_len_clamp;
    run_frame("R7", 1'b1, 16'h0003, 16'h0049, 4'd3, 8'd0, 50, 0, 1'b0, 8);
  endtask

  task automatic t_disable;
    run_frame("R8", 1'b0, 16'h00A9, 16'h00FF, 4'd8, 8'd0, 30, 0, 1'b0, 9);
  endtask

  task automatic t_gaps;
    run_frame("R9", 1'b1, 16'h00A9, 16'h00FF, 4'd8, 8'd3, 30, 2, 1'b0, 10);
  endtask

  task automatic t_midchange;
    run_frame("R3", 1'b1, 16'h001D, 16'h0033, 4'd10, 8'd4, 50, 0, 1'b1, 11);
    run_frame("R3", 1'b0, 16'h00A9, 16'h00FF, 4'd8, 8'd0, 20, 0, 1'b1, 12);
  endtask

  task automatic t_reframe;
    run_frame("R11", 1'b1, 16'h00A9, 16'h00FF, 4'd8, 8'd6, 15, 0, 1'b0, 13);
    run_frame("R11", 1'b1, 16'h00A9, 16'h0012, 4'd8, 8'd2, 40, 0, 1'b0, 14);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1", vld_o, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_standard;
    t_offset;
    t_taps;
    t_len_clamp;
    t_disable;
    t_gaps;
    t_midchange;
    t_reframe;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule